// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block drives the switches around an external analog integrator and comparator to perform a dual-slope conversion. A start request first shorts the integrator for a short auto-zero interval. The block then connects the unknown input for a fixed number of clocks and switches to a reference of opposite polarity. It counts clocks until the zero-crossing comparator reports that the integrator has discharged. That count, scaled by the ratio of integrate length to reference rate, is proportional to the mean input over the integrate window.

Set the integrate length to a whole period of an interfering signal, such as mains pickup, and the interference averages to nothing. The comparator is asynchronous to the sequencer clock, so it passes through a two-flop synchronizer. The block subtracts the synchronizer latency from the captured count. The result is therefore the number of de-integrate clocks that elapsed before the comparator output first went high. A discharge that runs past the counter limit ends the conversion with an overrange flag.

Top module: `dsc_seq`

## Requirements
- R1: After reset, sel_o is 2'b00, busy_o, done_o and ovr_o are 0, and result_o is 0.
- R2: A start_i sampled high while idle begins a conversion. sel_o is 2'b01 (integrator shorted) for ZERO_CLKS cycles starting the cycle after the start edge. It is then 2'b10 (input connected) for exactly INT_CLKS cycles, then 2'b11 (reference connected) until capture. sel_o is 2'b00 (all switches open) whenever the block is idle or done.
- R3: busy_o is high from the cycle after an accepted start through the done cycle, and low otherwise.
- R4: Number the de-integrate cycles from 0. If cmp_i is first high during cycle k, with k at most MAX_CNT, then result_o equals k and ovr_o is 0.
- R5: If cmp_i is already high throughout the start of de-integration (zero or negative net input), result_o is 0 and ovr_o is 0.
- R6: If cmp_i is high in none of de-integrate cycles 0 to MAX_CNT, the conversion still ends, ovr_o is 1 and result_o saturates at MAX_CNT.
- R7: done_o is a single-cycle pulse in the cycle after capture, and the block returns to idle in the following cycle.
- R8: result_o and ovr_o hold their captured values while idle and clear to 0 on the edge that accepts the next start.
- R9: start_i has no effect while busy_o is high, including in the done cycle: phase lengths and the result are unchanged, and no new conversion follows.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Zero-crossing comparator, asynchronous, high when integrator is at or below zero |
| sel_o | output | 2 | Switch select: 00 open, 01 auto-zero, 10 input, 11 reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | $clog2(MAX_CNT+1) | De-integrate count, held until next start |
| ovr_o | output | 1 | Overrange: no zero crossing within the counter limit |

## Verification
The bench closes the loop with an integrator model that charges and discharges by signed amounts per clock. The comparator therefore reacts to the sequencer's own switch timing, including the two-cycle synchronizer delay. A design that forgot to subtract that latency would report every result two counts high. A design that sampled the comparator too early would latch a stale high from auto-zero and return 0 for a positive input. The boundary pair at exactly MAX_CNT and one step above it catches an overrange test that is off by one. Restarts during integrate and during the done cycle expose a sequencer that re-arms or stretches a phase.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ZERO, PH_INTEG, PH_DEINT, PH_DONE
  } phase_e;

  typedef enum logic [1:0] {
    SW_OPEN  = 2'b00,
    SW_ZERO  = 2'b01,
    SW_INPUT = 2'b10,
    SW_REF   = 2'b11
  } sw_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

  AST_SYNC_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(stg_q[STAGES-2])); // R4
endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
  import dsc_pkg::*;
#(
  parameter int unsigned ZERO_CLKS = 4,
  parameter int unsigned INT_CLKS  = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   stop_i,
  output phase_e phase_o,
  output logic   clr_o
);
  localparam int unsigned LONGEST = (ZERO_CLKS > INT_CLKS) ? ZERO_CLKS : INT_CLKS;
  localparam int unsigned TMR_W   = $clog2(LONGEST + 1);
  localparam logic [TMR_W-1:0] ZERO_LAST = TMR_W'(ZERO_CLKS - 1);
  localparam logic [TMR_W-1:0] INT_LAST  = TMR_W'(INT_CLKS - 1);

  phase_e phase_q, phase_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    phase_d = phase_q;
    tmr_d   = tmr_q + 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        tmr_d = '0;
        if (start_i) phase_d = PH_ZERO;
      end
      PH_ZERO: if (tmr_q == ZERO_LAST) begin
        phase_d = PH_INTEG;
        tmr_d   = '0;
      end
      PH_INTEG: if (tmr_q == INT_LAST) begin
        phase_d = PH_DEINT;
        tmr_d   = '0;
      end
      PH_DEINT: begin
        tmr_d = '0;
        if (stop_i) phase_d = PH_DONE;
      end
      PH_DONE: begin
        tmr_d   = '0;
        phase_d = PH_IDLE;
      end
      default: begin
        tmr_d   = '0;
        phase_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
    end
  end

  assign phase_o = phase_q;
  assign clr_o   = (phase_q == PH_IDLE) && start_i;

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> phase_q == PH_ZERO); // R2
  AST_INTEG_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_INTEG) |-> $past(phase_q) == PH_ZERO); // R2
  AST_DEINT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DEINT && stop_i) |=> phase_q == PH_DONE); // R7
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_DONE |=> phase_q == PH_IDLE); // R7
endmodule

// File: rtl/dsc_deint_cnt.sv
module dsc_deint_cnt #(
  parameter int unsigned MAX_CNT = 60,
  parameter int unsigned LAT     = 2,
  localparam int unsigned RES_W  = $clog2(MAX_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             cmp_i,
  input  logic             clr_i,
  output logic             stop_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o
);
  localparam int unsigned RAW_MAX = MAX_CNT + LAT;
  localparam int unsigned RAW_W   = $clog2(RAW_MAX + 1);
  localparam logic [RAW_W-1:0] RAW_LIM = RAW_W'(RAW_MAX);
  localparam logic [RAW_W-1:0] LAT_V   = RAW_W'(LAT);

  logic [RAW_W-1:0] raw_q;
  logic [RAW_W-1:0] net;

  assign stop_o = active_i && (cmp_i || raw_q == RAW_LIM);
  // raw count includes the synchronizer delay; remove it
  assign net    = (raw_q >= LAT_V) ? (raw_q - LAT_V) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        raw_q <= '0;
    else if (!active_i) raw_q <= '0;
    else if (!stop_o)   raw_q <= raw_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
    end else if (clr_i) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
    end else if (stop_o) begin
      result_o <= cmp_i ? RES_W'(net) : RES_W'(MAX_CNT);
      ovr_o    <= !cmp_i;
    end
  end

  AST_RAW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> raw_q <= RAW_LIM); // R6
  AST_OVR_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> result_o == RES_W'(MAX_CNT)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !stop_o) |=> ($stable(result_o) && $stable(ovr_o))); // R8
  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (result_o == '0 && !ovr_o)); // R8
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
  import dsc_pkg::*;
#(
  parameter int unsigned ZERO_CLKS = 4,
  parameter int unsigned INT_CLKS  = 16,
  parameter int unsigned MAX_CNT   = 60
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         cmp_i,
  output logic [1:0]                   sel_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [$clog2(MAX_CNT+1)-1:0] result_o,
  output logic                         ovr_o
);
  phase_e phase;
  logic   cmp_s, stop, clr;

  dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  dsc_phase_ctrl #(.ZERO_CLKS(ZERO_CLKS), .INT_CLKS(INT_CLKS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .stop_i (stop),
    .phase_o(phase),
    .clr_o  (clr)
  );

  dsc_deint_cnt #(.MAX_CNT(MAX_CNT), .LAT(SYNC_STAGES)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(phase == PH_DEINT),
    .cmp_i   (cmp_s),
    .clr_i   (clr),
    .stop_o  (stop),
    .result_o(result_o),
    .ovr_o   (ovr_o)
  );

  always_comb begin
    unique case (phase)
      PH_ZERO:  sel_o = SW_ZERO;
      PH_INTEG: sel_o = SW_INPUT;
      PH_DEINT: sel_o = SW_REF;
      default:  sel_o = SW_OPEN;
    endcase
  end

  assign busy_o = (phase != PH_IDLE);
  assign done_o = (phase == PH_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_IDLE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sel_o == SW_OPEN); // R2
  AST_REF_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(sel_o) == SW_REF); // R7
endmodule

// File: tb/dsc_seq_bench.sv
module dsc_seq_bench;
  localparam int ZC = 4;
  localparam int IC = 16;
  localparam int MX = 60;
  localparam int RW = $clog2(MX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic [1:0] sel;
  logic busy, done;
  logic [RW-1:0] result;
  logic ovr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;
  int in_rate = 0;
  int ref_rate = 1;
  int vint;

  always #4 clk = ~clk;

  dsc_seq #(.ZERO_CLKS(ZC), .INT_CLKS(IC), .MAX_CNT(MX)) u_dsc_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .sel_o(sel), .busy_o(busy), .done_o(done), .result_o(result), .ovr_o(ovr)
  );

  // behavioural integrator and zero-crossing comparator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vint <= 0;
    else case (sel)
      2'b01:   vint <= 0;
      2'b10:   vint <= vint + in_rate;
      2'b11:   vint <= vint - ref_rate;
      default: vint <= vint;
    endcase
  end
  assign cmp = (vint <= 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc_total);
      finish_run();
    end
  end

  // runs one conversion; restart_at >= 0 pulses start in that busy cycle
  task automatic convert(input int a, input int r, input int restart_at, input string req);
    int nz = 0, ni = 0, cyc = 0, prod, n, exp_res;
    bit exp_ovr, busy_ok = 1'b1;
    in_rate = a; ref_rate = r;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(result == 0 && ovr == 1'b0, "R8 clear on start", int'(result), 0);
    while (!done && cyc < 500) begin
      if (sel == 2'b01) nz++;
      if (sel == 2'b10) ni++;
      if (!busy) busy_ok = 1'b0;
      start = (cyc == restart_at);
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    prod = a * IC;
    n = (prod <= 0) ? 0 : (prod + r - 1) / r;
    exp_ovr = (n > MX);
    exp_res = exp_ovr ? MX : n;
    check(done == 1'b1, {req, " done seen"}, int'(done), 1);
    check(nz == ZC, "R2 auto-zero length", nz, ZC);
    check(ni == IC, "R2 integrate length", ni, IC);
    check(busy_ok && busy, "R3 busy during conversion", int'(busy_ok), 1);
    check(sel == 2'b00, "R2 open in done", int'(sel), 0);
    check(int'(result) == exp_res, {req, " result"}, int'(result), exp_res);
    check(ovr == exp_ovr, {req, " overrange"}, int'(ovr), int'(exp_ovr));
    @(negedge clk);
    check(!done && !busy, "R7 single pulse then idle", int'(done), 0);
  endtask

  task automatic t_reset();
    check(sel == 2'b00, "R1 sel", int'(sel), 0);
    check(!busy && !done, "R1 busy/done", int'(busy), 0);
    check(result == 0 && !ovr, "R1 result/ovr", int'(result), 0);
  endtask

  task automatic t_nominal();
    convert(7, 3, -1, "R4 rounded up");
    convert(3, 4, -1, "R4 exact division");
    convert(1, 100, -1, "R4 one clock");
  endtask

  task automatic t_no_charge();
    convert(0, 4, -1, "R5 zero input");
    convert(-5, 4, -1, "R5 negative input");
  endtask

  task automatic t_full_scale();
    convert(15, 4, -1, "R4 at MAX_CNT");
    convert(16, 4, -1, "R6 above MAX_CNT");
  endtask

  task automatic t_hold();
    logic [RW-1:0] kept;
    convert(16, 4, -1, "R6 before hold");
    kept = result;
    repeat (6) @(negedge clk);
    check(result == kept && ovr, "R8 held while idle", int'(result), int'(kept));
  endtask

  task automatic t_restart_ignored();
    convert(7, 3, 10, "R9 start mid-integrate");
    convert(5, 2, 2, "R9 start during auto-zero");
    // start pulsed in the done cycle must not launch a conversion
    in_rate = 2; ref_rate = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!busy && sel == 2'b00, "R9 done-cycle start ignored", int'(busy), 0);
    @(negedge clk);
    check(!busy && int'(result) == 32, "R9 no relaunch", int'(result), 32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_no_charge();
    t_full_scale();
    t_hold();
    t_restart_ignored();
    finish_run();
  end
endmodule